// File: doc/BRIEF.md
# Compressed-Format Register ALU Execute Stage

This block is the execute stage for the register-to-register arithmetic and logic group of a 16-bit compressed instruction encoding. Each cycle it may accept one instruction halfword together with the two 32-bit operand values already read from the low register bank and the current condition flags. It returns a registered bundle one clock later. The bundle holds the computed value, a write-enable and the destination index for the register bank, the new condition flags and the total cycle cost that the sequencer should charge for the operation.

The operation group has sixteen members selected by a 4-bit field. Some members update only the sign and zero flags. Others also update carry and overflow. Three members update flags without writing a register. Shifts and rotates take their amount from the second operand. A core-variant input chooses between two multiplier behaviours. One has a fixed cost and keeps carry. The other clears carry and charges cycles according to the most significant nonzero byte of the first operand.

Top module: `cisa_alu_exec`

## Requirements
- R1: The operation is instruction bits [9:6], with codes 0..15 meaning AND, EOR, LSL, LSR, ASR, ADC, SBC, ROR, TST, NEG, CMP, CMN, ORR, MUL, BIC, MVN. The destination index, instruction bits [2:0], is returned on `rd_idx`.
- R2: All outputs are registered. `out_valid` is high exactly one cycle after a cycle with `in_valid` high. After reset, `out_valid` and `wr_en` are low.
- R3: AND, EOR, ORR, BIC (a & ~b), MVN (~b), TST (a & b), NEG (0 - b) and MUL (low 32 bits of a*b) change only N and Z. C and V pass through unchanged, except for MUL on variant 1. Flags are packed as N=bit3, Z=bit2, C=bit1, V=bit0.
- R4: LSL, LSR, ASR and ROR shift the first operand by the low byte of the second operand only, and leave V unchanged. An amount of 0 keeps the value and C. For LSL and LSR, an amount of 1..31 gives C as the last bit shifted out. An amount of exactly 32 gives 0 with C equal to bit 0 (LSL) or bit 31 (LSR). Amounts above 32 give 0 with C cleared. ASR by 32 or more fills every bit with bit 31, and C takes bit 31. ROR by a nonzero multiple of 32 keeps the value and sets C to bit 31.
- R5: ADC computes a + b + C. SBC computes a - b - (1 - C). Both set N, Z, the unsigned carry-out (meaning no borrow, for SBC) and the signed overflow of the whole operation.
- R6: CMP (a - b) and CMN (a + b) set N, Z, C and V. TST, CMP and CMN leave `wr_en` low. All other operations raise `wr_en` with `out_valid`.
- R7: `cost` is 2 for the four register shifts and 1 for every other operation except MUL.
- R8: When `core_sel` is 0, MUL costs 4 and keeps C. When `core_sel` is 1, MUL clears C and costs 5, 4, 3 or 2 when the highest nonzero byte of the first operand is byte 3, 2, 1 or 0 (a zero operand counts as byte 0).
- R9: For every operation, N equals bit 31 of `result` and Z is set exactly when `result` is zero. `result` carries the computed value even when the register is not written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction strobe |
| instr | input | 16 | Instruction halfword |
| opa | input | 32 | Value of register [2:0] (first operand) |
| opb | input | 32 | Value of register [5:3] (second operand) |
| flags_in | input | 4 | Current N,Z,C,V |
| core_sel | input | 1 | Core variant for multiply behaviour |
| out_valid | output | 1 | Result bundle valid |
| result | output | 32 | Computed value |
| wr_en | output | 1 | Destination register write strobe |
| rd_idx | output | 3 | Destination register index |
| flags_out | output | 4 | Updated N,Z,C,V |
| cost | output | 4 | Total cycle cost of the operation |

## Verification
The hardest cases to reach are the shift-amount boundaries, where the carry comes from a different place for each shift kind. These are amounts 0, 31, 32 and 33, and amounts whose low byte differs from the full register value, such as 256 and 288. They matter only when the first operand has distinct bit 0 and bit 31 and the incoming carry is both set and clear. The stimulus sweeps every amount from 0 to 40 plus several values above 255, against first operands with mixed end bits, under all incoming flag combinations. The ADC/SBC carry-in interaction is reached by pairing the incoming carry with operands at 0, 0x7FFFFFFF, 0x80000000 and 0xFFFFFFFF. Multiply cost is reached through operands whose top nonzero byte steps from byte 3 down to byte 0.

// File: rtl/cisa_alu_pkg.sv
package cisa_alu_pkg;

    localparam int DW     = 32;
    localparam int CW     = 4;
    localparam int FLAG_N = 3;
    localparam int FLAG_Z = 2;
    localparam int FLAG_C = 1;
    localparam int FLAG_V = 0;

    typedef enum logic [3:0] {
        OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_LSL = 4'd2,  OP_LSR = 4'd3,
        OP_ASR = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_ROR = 4'd7,
        OP_TST = 4'd8,  OP_NEG = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
        OP_ORR = 4'd12, OP_MUL = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        logic [DW-1:0] value;
        logic [3:0]    flags;
        logic          wr;
        logic [CW-1:0] cost;
    } exec_bundle_t;

    function automatic logic is_shift(alu_op_e op);
        return (op == OP_LSL) || (op == OP_LSR) || (op == OP_ASR) || (op == OP_ROR);
    endfunction

    function automatic logic is_flag_only(alu_op_e op);
        return (op == OP_TST) || (op == OP_CMP) || (op == OP_CMN);
    endfunction

    function automatic shift_kind_e shift_kind(alu_op_e op);
        case (op)
            OP_LSL:  return SH_LSL;
            OP_LSR:  return SH_LSR;
            OP_ASR:  return SH_ASR;
            default: return SH_ROR;
        endcase
    endfunction

endpackage

// File: rtl/cisa_shift_unit.sv
module cisa_shift_unit
    import cisa_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int AMT_W = 8
) (
    input  shift_kind_e      kind,
    input  logic [WIDTH-1:0] x,
    input  logic [AMT_W-1:0] amt,
    input  logic             c_in,
    output logic [WIDTH-1:0] y,
    output logic             c_out
);
    localparam int SL = $clog2(WIDTH);

    logic [SL-1:0]      sh;
    logic               amt_zero;
    logic               amt_small;
    logic               amt_exact;
    logic [WIDTH:0]     lsl_ext;
    logic [WIDTH:0]     lsr_ext;
    logic [WIDTH:0]     asr_ext;
    logic [2*WIDTH-1:0] ror_dbl;

    always_comb begin
        sh        = amt[SL-1:0];
        amt_zero  = (amt == '0);
        amt_small = (int'(amt) < WIDTH);
        amt_exact = (int'(amt) == WIDTH);
        lsl_ext   = {1'b0, x} << sh;
        lsr_ext   = {x, 1'b0} >> sh;
        asr_ext   = $unsigned($signed({x, 1'b0}) >>> sh);
        ror_dbl   = {x, x} >> sh;
    end

    always_comb begin
        y     = x;
        c_out = c_in;
        if (!amt_zero) begin
            case (kind)
                SH_LSL: begin
                    if (amt_small) begin
                        y = lsl_ext[WIDTH-1:0]; c_out = lsl_ext[WIDTH];
                    end else if (amt_exact) begin
                        y = '0; c_out = x[0];
                    end else begin
                        y = '0; c_out = 1'b0;
                    end
                end
                SH_LSR: begin
                    if (amt_small) begin
                        y = lsr_ext[WIDTH:1]; c_out = lsr_ext[0];
                    end else if (amt_exact) begin
                        y = '0; c_out = x[WIDTH-1];
                    end else begin
                        y = '0; c_out = 1'b0;
                    end
                end
                SH_ASR: begin
                    if (amt_small) begin
                        y = asr_ext[WIDTH:1]; c_out = asr_ext[0];
                    end else begin
                        y = {WIDTH{x[WIDTH-1]}}; c_out = x[WIDTH-1];
                    end
                end
                default: begin
                    y     = ror_dbl[WIDTH-1:0];
                    c_out = ror_dbl[WIDTH-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/cisa_arith_unit.sv
module cisa_arith_unit
    import cisa_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  alu_op_e          op,
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             c_in,
    output logic [WIDTH-1:0] y,
    output logic             c_out,
    output logic             v_out,
    output logic             is_adder
);
    logic [WIDTH-1:0] add_x;
    logic [WIDTH-1:0] add_y;
    logic             add_ci;
    logic [WIDTH:0]   sum;

    always_comb begin
        add_x    = a;
        add_y    = b;
        add_ci   = 1'b0;
        is_adder = 1'b1;
        case (op)
            OP_ADC: begin add_y = b;  add_ci = c_in; end
            OP_SBC: begin add_y = ~b; add_ci = c_in; end
            OP_CMP: begin add_y = ~b; add_ci = 1'b1; end
            OP_CMN: begin add_y = b;  add_ci = 1'b0; end
            OP_NEG: begin add_x = '0; add_y = ~b; add_ci = 1'b1; end
            default: is_adder = 1'b0;
        endcase
        sum   = {1'b0, add_x} + {1'b0, add_y} + {{WIDTH{1'b0}}, add_ci};
        c_out = sum[WIDTH];
        v_out = (add_x[WIDTH-1] == add_y[WIDTH-1]) && (sum[WIDTH-1] != add_x[WIDTH-1]);
    end

    always_comb begin
        case (op)
            OP_AND, OP_TST: y = a & b;
            OP_EOR:         y = a ^ b;
            OP_ORR:         y = a | b;
            OP_BIC:         y = a & ~b;
            OP_MVN:         y = ~b;
            default:        y = sum[WIDTH-1:0];
        endcase
    end
endmodule

// File: rtl/cisa_mul_unit.sv
module cisa_mul_unit
    import cisa_alu_pkg::*;
#(
    parameter int WIDTH      = 32,
    parameter int COST_W     = 4,
    parameter int FIXED_ICYC = 3
) (
    input  logic [WIDTH-1:0]  a,
    input  logic [WIDTH-1:0]  b,
    input  logic              variant,
    output logic [WIDTH-1:0]  y,
    output logic [COST_W-1:0] cost
);
    localparam int NB = WIDTH / 8;

    logic [NB-1:0]     byte_nz;
    logic [COST_W-1:0] early_cost;

    assign y = a * b;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign byte_nz[g] = |a[8*g +: 8];
    end

    always_comb begin
        early_cost = COST_W'(2);
        for (int i = 1; i < NB; i++) begin
            if (byte_nz[i]) early_cost = COST_W'(i + 2);
        end
        cost = variant ? early_cost : COST_W'(FIXED_ICYC + 1);
    end
endmodule

// File: rtl/cisa_alu_exec.sv
module cisa_alu_exec
    import cisa_alu_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [15:0]   instr,
    input  logic [31:0]   opa,
    input  logic [31:0]   opb,
    input  logic [3:0]    flags_in,
    input  logic          core_sel,
    output logic          out_valid,
    output logic [31:0]   result,
    output logic          wr_en,
    output logic [2:0]    rd_idx,
    output logic [3:0]    flags_out,
    output logic [3:0]    cost
);
    alu_op_e       op;
    logic          unused_hi;
    logic [DW-1:0] sh_y,  ar_y,  mu_y;
    logic          sh_c,  ar_c,  ar_v, ar_is_add;
    logic [CW-1:0] mu_cost;
    exec_bundle_t  nxt;
    exec_bundle_t  cur;
    logic [2:0]    rd_q;
    logic          vld_q;

    assign op        = alu_op_e'(instr[9:6]);
    assign unused_hi = ^instr[15:10] ^ ^instr[5:3];

    cisa_shift_unit #(.WIDTH(DW), .AMT_W(8)) u_shift (
        .kind (shift_kind(op)),
        .x    (opa),
        .amt  (opb[7:0]),
        .c_in (flags_in[FLAG_C]),
        .y    (sh_y),
        .c_out(sh_c)
    );

    cisa_arith_unit #(.WIDTH(DW)) u_arith (
        .op      (op),
        .a       (opa),
        .b       (opb),
        .c_in    (flags_in[FLAG_C]),
        .y       (ar_y),
        .c_out   (ar_c),
        .v_out   (ar_v),
        .is_adder(ar_is_add)
    );

    cisa_mul_unit #(.WIDTH(DW), .COST_W(CW), .FIXED_ICYC(3)) u_mul (
        .a      (opa),
        .b      (opb),
        .variant(core_sel),
        .y      (mu_y),
        .cost   (mu_cost)
    );

    always_comb begin
        nxt.flags = flags_in;
        nxt.wr    = !is_flag_only(op);
        if (is_shift(op)) begin
            nxt.value               = sh_y;
            nxt.flags[FLAG_C]       = sh_c;
            nxt.cost                = CW'(2);
        end else if (op == OP_MUL) begin
            nxt.value               = mu_y;
            nxt.cost                = mu_cost;
            if (core_sel) nxt.flags[FLAG_C] = 1'b0;
        end else begin
            nxt.value               = ar_y;
            nxt.cost                = CW'(1);
            if (ar_is_add && (op != OP_NEG)) begin
                nxt.flags[FLAG_C]   = ar_c;
                nxt.flags[FLAG_V]   = ar_v;
            end
        end
        nxt.flags[FLAG_N] = nxt.value[DW-1];
        nxt.flags[FLAG_Z] = (nxt.value == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            cur   <= '0;
            rd_q  <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                cur  <= nxt;
                rd_q <= instr[2:0];
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = cur.value;
    assign wr_en     = vld_q & cur.wr;
    assign rd_idx    = rd_q;
    assign flags_out = cur.flags;
    assign cost      = cur.cost;
endmodule

// File: rtl/cisa_alu_exec_chk.sv
module cisa_alu_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [15:0] instr,
    input logic [31:0] opa,
    input logic [31:0] opb,
    input logic [3:0]  flags_in,
    input logic        core_sel,
    input logic        out_valid,
    input logic [31:0] result,
    input logic        wr_en,
    input logic [2:0]  rd_idx,
    input logic [3:0]  flags_out,
    input logic [3:0]  cost
);
    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R6
    write_gate_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> out_valid);
    // R6
    flag_only_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (instr[9:6] == 4'd8 || instr[9:6] == 4'd10 || instr[9:6] == 4'd11))
        |=> !wr_en);
    // R1
    dest_echo_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (rd_idx == $past(instr[2:0])));
    // R4
    shift_keeps_v_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (instr[9:6] == 4'd2 || instr[9:6] == 4'd3 ||
                      instr[9:6] == 4'd4 || instr[9:6] == 4'd7))
        |=> (flags_out[0] == $past(flags_in[0])) && (cost == 4'd2));
    // R8
    mul_v1_clears_c_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && core_sel && instr[9:6] == 4'd13) |=> !flags_out[1]);
    // R9
    nz_consistent_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (flags_out[3] == result[31]) && (flags_out[2] == (result == 32'd0)));
    // R7
    cost_range_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (cost >= 4'd1) && (cost <= 4'd5));

    logic unused_chk;
    assign unused_chk = ^opa ^ ^opb;
endmodule

bind cisa_alu_exec cisa_alu_exec_chk u_chk (.*);

// File: tb/sim_cisa_alu_exec.sv
module sim_cisa_alu_exec;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [15:0] instr;
    logic [31:0] opa, opb;
    logic [3:0]  flags_in;
    logic        core_sel;
    logic        out_valid;
    logic [31:0] result;
    logic        wr_en;
    logic [2:0]  rd_idx;
    logic [3:0]  flags_out;
    logic [3:0]  cost;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    cisa_alu_exec u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic model(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [3:0] fl, input logic v,
                         output logic [31:0] r, output logic [3:0] f,
                         output logic wr, output logic [3:0] cy);
        logic [63:0] t;
        longint sa, sb, sr;
        int amt;
        logic c, ov;
        c  = fl[1];
        ov = fl[0];
        wr = !(op == 8 || op == 10 || op == 11);
        cy = 4'd1;
        amt = int'(b[7:0]);
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        case (op)
            0, 8: r = a & b;
            1:  r = a ^ b;
            12: r = a | b;
            14: r = a & ~b;
            15: r = ~b;
            9:  r = 32'd0 - b;
            13: begin
                r = a * b;
                if (!v) cy = 4'd4;
                else begin
                    c = 1'b0;
                    if (a[31:24] != 0) cy = 4'd5;
                    else if (a[23:16] != 0) cy = 4'd4;
                    else if (a[15:8] != 0) cy = 4'd3;
                    else cy = 4'd2;
                end
            end
            2: begin
                cy = 4'd2;
                t = {32'd0, a} << amt;
                r = t[31:0];
                if (amt != 0) c = t[32];
            end
            3: begin
                cy = 4'd2;
                t = {a, 32'd0} >> amt;
                r = t[63:32];
                if (amt != 0) c = t[31];
            end
            4: begin
                cy = 4'd2;
                t = $unsigned($signed({a, 32'd0}) >>> amt);
                r = t[63:32];
                if (amt != 0) c = t[31];
            end
            7: begin
                cy = 4'd2;
                t = {a, a} >> (amt % 32);
                r = t[31:0];
                if (amt != 0) c = r[31];
            end
            5: begin
                r  = a + b + {31'd0, fl[1]};
                c  = ({32'd0, a} + {32'd0, b} + {63'd0, fl[1]}) > 64'hFFFF_FFFF;
                sr = sa + sb + longint'(fl[1]);
                ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            6: begin
                r  = a - b - {31'd0, !fl[1]};
                c  = {32'd0, a} >= ({32'd0, b} + {63'd0, !fl[1]});
                sr = sa - sb - longint'(!fl[1]);
                ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            10: begin
                r  = a - b;
                c  = a >= b;
                sr = sa - sb;
                ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            default: begin
                r  = a + b;
                c  = ({32'd0, a} + {32'd0, b}) > 64'hFFFF_FFFF;
                sr = sa + sb;
                ov = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
        endcase
        f = {r[31], (r == 32'd0), c, ov};
    endtask

    function automatic string tag_of(input int op);
        if (op == 2 || op == 3 || op == 4 || op == 7) return "R4";
        if (op == 5 || op == 6) return "R5";
        if (op == 10 || op == 11) return "R6";
        if (op == 13) return "R8";
        return "R3";
    endfunction

    task automatic run_one(input int op, input logic [31:0] a, input logic [31:0] b,
                           input logic [3:0] fl, input logic v, input logic [2:0] rd);
        logic [31:0] er;
        logic [3:0]  ef, ec;
        logic        ew;
        model(op, a, b, fl, v, er, ef, ew, ec);
        in_valid = 1'b1;
        instr    = {6'b010000, op[3:0], 3'(rd + 3'd5), rd};
        opa      = a;
        opb      = b;
        flags_in = fl;
        core_sel = v;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "out_valid", 32'(out_valid), 32'd1);
        check(tag_of(op), $sformatf("result op=%0d a=%h b=%h", op, a, b), result, er);
        check(tag_of(op), $sformatf("flags op=%0d a=%h b=%h f=%h", op, a, b, fl), 32'(flags_out), 32'(ef));
        check("R9", "N/Z vs result", 32'(flags_out[3:2]), 32'({er[31], er == 32'd0}));
        check("R6", "wr_en", 32'(wr_en), 32'(ew));
        check(op == 13 ? "R8" : "R7", $sformatf("cost op=%0d a=%h v=%0d", op, a, v), 32'(cost), 32'(ec));
        check("R1", "rd_idx", 32'(rd_idx), 32'(rd));
    endtask

    logic [31:0] pat [12] = '{32'h0, 32'h1, 32'h2, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h8000_0001, 32'h1234_5678,
                              32'h00FF_0000, 32'h0000_FF00, 32'hF000_0000, 32'h0000_007F};
    logic [31:0] amts [8] = '{32'd255, 32'd256, 32'd288, 32'd289, 32'h0000_0140,
                              32'hFFFF_FF20, 32'd64, 32'd96};
    logic [3:0]  fls  [4] = '{4'b0000, 4'b0010, 4'b0001, 4'b1111};

    initial begin
        rst = 1'b1; in_valid = 1'b0; instr = '0; opa = '0; opb = '0;
        flags_in = '0; core_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: reset state
        check("R2", "out_valid after reset", 32'(out_valid), 32'd0);
        check("R2", "wr_en after reset", 32'(wr_en), 32'd0);
        @(negedge clk);
        check("R2", "idle out_valid", 32'(out_valid), 32'd0);

        for (int v = 0; v < 2; v++) begin
            for (int op = 0; op < 16; op++) begin
                for (int fi = 0; fi < 4; fi++) begin
                    for (int ai = 0; ai < 12; ai++) begin
                        if (op == 2 || op == 3 || op == 4 || op == 7) begin
                            // R4: amounts around the width boundary and above the low byte
                            for (int s = 0; s <= 40; s++)
                                run_one(op, pat[ai], 32'(s), fls[fi], v[0], 3'(s));
                            for (int k = 0; k < 8; k++)
                                run_one(op, pat[ai], amts[k], fls[fi], v[0], 3'(k));
                        end else begin
                            for (int bi = 0; bi < 12; bi++)
                                run_one(op, pat[ai], pat[bi], fls[fi], v[0], 3'(ai + bi));
                        end
                    end
                end
            end
        end
        // R2: output drops when no strobe
        @(negedge clk);
        check("R2", "out_valid after idle", 32'(out_valid), 32'd0);
        check("R6", "wr_en after idle", 32'(wr_en), 32'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule